// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer. It counts enable ticks through an 8-bit prescaler stage and a 7-bit upper stage. A 3-bit span code picks the timeout length: 256 × 2^n ticks. A static option picks where the ticks come from. They are either a free-running low-frequency oscillator tick, or the block's own clock divided by four. When the count reaches the end of the selected span, the block emits a one-cycle reset pulse. The pulse is a full chip reset while the device is awake and a warm-reset request while it is asleep. The block also raises a sticky expiry flag.

Software keeps the watchdog quiet by issuing kick commands. A second static option picks the kick policy:

- **Single-kick policy:** one plain kick command restarts the count.
- **Two-kick policy:** two distinct commands, kick A and kick B, must both be seen, in either order or together. A three-state kick machine remembers which half has arrived. Its states are `KICK_IDLE` (nothing seen), `KICK_HAVE_A` (A seen, waiting for B) and `KICK_HAVE_B` (B seen, waiting for A).
  - `KICK_IDLE` goes to `KICK_HAVE_A` on A alone, to `KICK_HAVE_B` on B alone, and stays in `KICK_IDLE` (issuing a restart) when both arrive in the same cycle.
  - `KICK_HAVE_A` returns to `KICK_IDLE` with a restart on B.
  - `KICK_HAVE_B` returns to `KICK_IDLE` with a restart on A.
  - A sleep command sends any state to `KICK_IDLE` and restarts the count. The single-kick policy holds `KICK_IDLE`.

A second machine shapes the reset output. Its states are `FIRE_NONE`, `FIRE_CHIP` and `FIRE_WARM`. Any state goes to `FIRE_CHIP` on expiry while awake, to `FIRE_WARM` on expiry while asleep, and to `FIRE_NONE` otherwise.

Top module: `wdog_guard`

## Requirements
- R1: While `rst_n` is low, `chip_rst_o`, `warm_rst_o` and `expired_o` are 0. After release the count starts from zero, so with one tick per cycle and `span_sel_i`=0 the first pulse appears 256 cycles after release.
- R2: With `use_osc_i`=1 every cycle with `osc_tick_i`=1 is one tick. A timeout pulse appears 256 × 2^`span_sel_i` ticks after the last restart (code 0 → 256, code 3 → 2048, code 7 → 32768).
- R3: With `use_osc_i`=0, `osc_tick_i` is ignored and one tick occurs every fourth clock cycle. The timeout comes 1021 to 1024 cycles after a restart for `span_sel_i`=0.
- R4: A timeout while `sleeping_i`=0 gives a `chip_rst_o` pulse exactly one cycle wide in the cycle after the final tick, with `warm_rst_o` low.
- R5: A timeout while `sleeping_i`=1 gives a one-cycle `warm_rst_o` pulse with `chip_rst_o` low.
- R6: `expired_o` rises with the timeout pulse and stays 1 until reset or a restart.
- R7: With `dual_mode_i`=0, `cmd_kick_i` restarts the count and clears `expired_o`, while `cmd_kick_a_i` and `cmd_kick_b_i` have no effect.
- R8: With `dual_mode_i`=1, the count restarts only once both `cmd_kick_a_i` and `cmd_kick_b_i` have been seen, in either order or in the same cycle. Either one alone, and `cmd_kick_i`, leave the count running and `expired_o` unchanged.
- R9: `cmd_sleep_i` restarts the count, clears `expired_o`, and discards a half-completed two-kick sequence.
- R10: A restart in the same cycle as the final tick wins. No pulse is produced, the flag stays 0, and the next timeout is a full span later.
- R11: Without a restart, the count wraps after a timeout, and the next pulse follows one full span later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_osc_i | input | 1 | Static tick source: 1 = oscillator tick, 0 = clock divided by four |
| osc_tick_i | input | 1 | Synchronous one-cycle oscillator tick |
| dual_mode_i | input | 1 | Static kick policy: 1 = two-kick, 0 = single-kick |
| span_sel_i | input | 3 | Timeout span code n, span = 256 × 2^n ticks |
| cmd_kick_i | input | 1 | Single-kick restart command |
| cmd_kick_a_i | input | 1 | First half of the two-kick restart |
| cmd_kick_b_i | input | 1 | Second half of the two-kick restart |
| cmd_sleep_i | input | 1 | Sleep command, restarts the count |
| sleeping_i | input | 1 | Device is in the sleep state |
| chip_rst_o | output | 1 | One-cycle full chip reset request |
| warm_rst_o | output | 1 | One-cycle warm reset request |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
Two functions can fall in the same cycle: a restart command and the final tick of the span.

The bench provokes this by timing the kick to be sampled on exactly the edge where the count sits at its terminal value. It then judges three outcomes:
- no pulse appears in that cycle;
- the flag reads 0;
- the scoreboard's next expected pulse, one full span later, is the only one that arrives.

The same-cycle arrival of kick A and kick B under the two-kick policy is exercised as well, and must act as one complete restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        KICK_IDLE   = 2'd0,
        KICK_HAVE_A = 2'd1,
        KICK_HAVE_B = 2'd2
    } kick_state_t;

    typedef enum logic [1:0] {
        FIRE_NONE = 2'd0,
        FIRE_CHIP = 2'd1,
        FIRE_WARM = 2'd2
    } fire_state_t;

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int SYS_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_osc_i,
    input  logic osc_tick_i,
    output logic tick_o
);
    logic tick_sys;

    generate
        if (SYS_DIV <= 1) begin : g_nodiv
            assign tick_sys = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(SYS_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == DIV_LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick_sys = (div_q == DIV_LAST);
        end
    endgenerate

    assign tick_o = use_osc_i ? osc_tick_i : tick_sys;

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
    parameter int PRE_W  = 8,
    parameter int POST_W = 7,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] span_sel_i,
    output logic             expire_o
);
    localparam int TOT_W  = PRE_W + POST_W;
    localparam int N_SPAN = 2 ** SEL_W;

    logic [PRE_W-1:0]  pre_q;
    logic [POST_W-1:0] post_q;
    logic [TOT_W-1:0]  chain_w;
    logic [N_SPAN-1:0] term_vec;
    logic              pre_carry;
    logic              at_term;

    assign chain_w   = {post_q, pre_q};
    assign pre_carry = tick_i & (&pre_q);

    // one terminal detector per span code: all low bits of the span at one
    for (genvar j = 0; j < N_SPAN; j++) begin : g_span
        localparam int LEN = ((PRE_W + j) > TOT_W) ? TOT_W : (PRE_W + j);
        assign term_vec[j] = &chain_w[LEN-1:0];
    end

    assign at_term  = term_vec[span_sel_i];
    assign expire_o = tick_i & at_term & ~restart_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart_i || expire_o) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_q <= '0;
        end else if (restart_i || expire_o) begin
            post_q <= '0;
        end else if (pre_carry) begin
            post_q <= post_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_kick_fsm.sv
module wdog_kick_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode_i,
    input  logic cmd_kick_i,
    input  logic cmd_kick_a_i,
    input  logic cmd_kick_b_i,
    input  logic cmd_sleep_i,
    output logic restart_o
);
    kick_state_t state_q, state_d;
    logic        kick_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KICK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        kick_done = 1'b0;
        if (!dual_mode_i) begin
            state_d   = KICK_IDLE;
            kick_done = cmd_kick_i;
        end else begin
            unique case (state_q)
                KICK_IDLE: begin
                    if (cmd_kick_a_i && cmd_kick_b_i) begin
                        kick_done = 1'b1;
                    end else if (cmd_kick_a_i) begin
                        state_d = KICK_HAVE_A;
                    end else if (cmd_kick_b_i) begin
                        state_d = KICK_HAVE_B;
                    end
                end
                KICK_HAVE_A: begin
                    if (cmd_kick_b_i) begin
                        kick_done = 1'b1;
                        state_d   = KICK_IDLE;
                    end
                end
                KICK_HAVE_B: begin
                    if (cmd_kick_a_i) begin
                        kick_done = 1'b1;
                        state_d   = KICK_IDLE;
                    end
                end
                default: state_d = KICK_IDLE;
            endcase
        end
        if (cmd_sleep_i) begin
            state_d = KICK_IDLE;
        end
    end

    assign restart_o = kick_done | cmd_sleep_i;

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int  PRE_W   = 8,
    parameter int  POST_W  = 7,
    parameter int  SYS_DIV = 4,
    localparam int SEL_W   = $clog2(POST_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_osc_i,
    input  logic             osc_tick_i,
    input  logic             dual_mode_i,
    input  logic [SEL_W-1:0] span_sel_i,
    input  logic             cmd_kick_i,
    input  logic             cmd_kick_a_i,
    input  logic             cmd_kick_b_i,
    input  logic             cmd_sleep_i,
    input  logic             sleeping_i,
    output logic             chip_rst_o,
    output logic             warm_rst_o,
    output logic             expired_o
);
    logic        tick;
    logic        restart;
    logic        expire;
    fire_state_t fire_q, fire_d;
    logic        flag_q;

    wdog_tick #(.SYS_DIV(SYS_DIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_osc_i  (use_osc_i),
        .osc_tick_i (osc_tick_i),
        .tick_o     (tick)
    );

    wdog_kick_fsm u_kick (
        .clk          (clk),
        .rst_n        (rst_n),
        .dual_mode_i  (dual_mode_i),
        .cmd_kick_i   (cmd_kick_i),
        .cmd_kick_a_i (cmd_kick_a_i),
        .cmd_kick_b_i (cmd_kick_b_i),
        .cmd_sleep_i  (cmd_sleep_i),
        .restart_o    (restart)
    );

    wdog_chain #(.PRE_W(PRE_W), .POST_W(POST_W), .SEL_W(SEL_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .restart_i  (restart),
        .span_sel_i (span_sel_i),
        .expire_o   (expire)
    );

    // reset-kind state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= FIRE_NONE;
        end else begin
            fire_q <= fire_d;
        end
    end

    always_comb begin
        unique case (fire_q)
            FIRE_NONE, FIRE_CHIP, FIRE_WARM: begin
                if (!expire) begin
                    fire_d = FIRE_NONE;
                end else if (sleeping_i) begin
                    fire_d = FIRE_WARM;
                end else begin
                    fire_d = FIRE_CHIP;
                end
            end
            default: fire_d = FIRE_NONE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        chip_rst_o = 1'b0;
        warm_rst_o = 1'b0;
        unique case (fire_q)
            FIRE_CHIP: chip_rst_o = 1'b1;
            FIRE_WARM: warm_rst_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restart) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end
    end

    assign expired_o = flag_q;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic dual_mode_i,
    input logic cmd_kick_i,
    input logic cmd_kick_a_i,
    input logic cmd_kick_b_i,
    input logic cmd_sleep_i,
    input logic sleeping_i,
    input logic chip_rst_o,
    input logic warm_rst_o,
    input logic expired_o
);
    assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> !warm_rst_o);

    assert_chip_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |=> !chip_rst_o);

    assert_chip_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> !$past(sleeping_i));

    assert_warm_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> $past(sleeping_i));

    assert_warm_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |=> !warm_rst_o);

    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> (chip_rst_o || warm_rst_o));

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !cmd_kick_i && !cmd_kick_a_i && !cmd_kick_b_i && !cmd_sleep_i)
        |=> expired_o);

    assert_single_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode_i && cmd_kick_i) |=> (!expired_o && !chip_rst_o && !warm_rst_o));

    assert_sleep_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sleep_i |=> (!expired_o && !chip_rst_o && !warm_rst_o));
endmodule

bind wdog_guard wdog_guard_chk u_wdog_guard_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dual_mode_i  (dual_mode_i),
    .cmd_kick_i   (cmd_kick_i),
    .cmd_kick_a_i (cmd_kick_a_i),
    .cmd_kick_b_i (cmd_kick_b_i),
    .cmd_sleep_i  (cmd_sleep_i),
    .sleeping_i   (sleeping_i),
    .chip_rst_o   (chip_rst_o),
    .warm_rst_o   (warm_rst_o),
    .expired_o    (expired_o)
);

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_osc = 1'b1;
    logic       osc_tick = 1'b1;
    logic       dual_mode = 1'b0;
    logic [2:0] span_sel = 3'd0;
    logic       cmd_kick = 1'b0;
    logic       cmd_kick_a = 1'b0;
    logic       cmd_kick_b = 1'b0;
    logic       cmd_sleep = 1'b0;
    logic       sleeping = 1'b0;
    logic       chip_rst, warm_rst, expired;

    always #2 clk = ~clk;

    wdog_guard i_wdog_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .use_osc_i    (use_osc),
        .osc_tick_i   (osc_tick),
        .dual_mode_i  (dual_mode),
        .span_sel_i   (span_sel),
        .cmd_kick_i   (cmd_kick),
        .cmd_kick_a_i (cmd_kick_a),
        .cmd_kick_b_i (cmd_kick_b),
        .cmd_sleep_i  (cmd_sleep),
        .sleeping_i   (sleeping),
        .chip_rst_o   (chip_rst),
        .warm_rst_o   (warm_rst),
        .expired_o    (expired)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        int unsigned slack;
        bit          warm;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;

    // monitor: every pulse must match the head of the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (chip_rst || warm_rst)) begin
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL R10/R7: unexpected pulse cyc=%0d chip=%0b warm=%0b, expected none",
                         cyc, chip_rst, warm_rst);
            end else begin
                e = sb_q.pop_front();
                if (cyc + e.slack < e.at || cyc > e.at || warm_rst != e.warm || chip_rst == e.warm) begin
                    bad++;
                    $display("FAIL %s: pulse cyc=%0d chip=%0b warm=%0b, expected cyc %0d..%0d warm=%0b",
                             e.req, cyc, chip_rst, warm_rst, e.at - e.slack, e.at, e.warm);
                end
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // which: 0 kick, 1 kick A, 2 kick B, 3 sleep, 4 kick A and B together
    task automatic send(input int which, output int unsigned k);
        @(negedge clk);
        case (which)
            0: cmd_kick = 1'b1;
            1: cmd_kick_a = 1'b1;
            2: cmd_kick_b = 1'b1;
            3: cmd_sleep = 1'b1;
            default: begin cmd_kick_a = 1'b1; cmd_kick_b = 1'b1; end
        endcase
        @(posedge clk);
        #1;
        k = cyc;
        cmd_kick = 1'b0; cmd_kick_a = 1'b0; cmd_kick_b = 1'b0; cmd_sleep = 1'b0;
    endtask

    task automatic expect_pulse(input int unsigned at, input int unsigned slack,
                                input bit warm, input string req);
        exp_t e;
        e.at = at; e.slack = slack; e.warm = warm; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_to(input int unsigned c);
        while (cyc < c) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_drain();
        while (sb_q.size() != 0) begin
            @(negedge clk);
            if (sb_q.size() != 0 && cyc > sb_q[0].at + 4) begin
                total++;
                bad++;
                $display("FAIL %s: no pulse by cyc=%0d, expected at %0d", sb_q[0].req, cyc, sb_q[0].at);
                void'(sb_q.pop_front());
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung at cyc=%0d, expected completion", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned k, k1, k2;
        // R1: reset state
        repeat (4) @(negedge clk);
        check_bit("R1 chip in reset", chip_rst, 1'b0);
        check_bit("R1 warm in reset", warm_rst, 1'b0);
        check_bit("R1 flag in reset", expired, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        k = cyc;
        expect_pulse(k + 256, 0, 1'b0, "R1 first span after release");
        wait_drain();
        send(0, k);

        // R2/R4/R6/R11 with one tick per cycle
        expect_pulse(k + 256, 0, 1'b0, "R2 R4 span code 0");
        wait_drain();
        check_bit("R6 flag after timeout", expired, 1'b1);
        repeat (20) @(negedge clk);
        check_bit("R6 flag held", expired, 1'b1);
        expect_pulse(k + 512, 0, 1'b0, "R11 wrap to next span");
        wait_drain();
        send(0, k);
        check_bit("R7 kick clears flag", expired, 1'b0);

        // R2 span code 3
        span_sel = 3'd3;
        send(0, k);
        expect_pulse(k + 2048, 0, 1'b0, "R2 span code 3");
        wait_drain();
        span_sel = 3'd0;

        // R7: A/B kicks ignored in single policy
        send(0, k);
        expect_pulse(k + 256, 0, 1'b0, "R7 A/B ignored in single policy");
        wait_to(k + 100);
        send(1, k1);
        wait_to(k + 150);
        send(2, k1);
        wait_drain();
        check_bit("R7 A/B leave flag set", expired, 1'b1);

        // R7: mid-span kick restarts
        send(0, k);
        wait_to(k + 200);
        send(0, k1);
        expect_pulse(k1 + 256, 0, 1'b0, "R7 mid-span kick restarts");
        wait_drain();

        // R8: two-kick policy
        dual_mode = 1'b1;
        send(4, k);
        check_bit("R8 A and B together clear flag", expired, 1'b0);
        wait_to(k + 100);
        send(1, k1);
        wait_to(k + 150);
        send(0, k1);
        wait_to(k + 200);
        send(2, k2);
        expect_pulse(k2 + 256, 0, 1'b0, "R8 A then B restarts, plain kick ignored");
        wait_drain();
        send(2, k);
        check_bit("R8 B alone keeps flag", expired, 1'b1);
        wait_to(k + 50);
        send(1, k1);
        check_bit("R8 B then A clears flag", expired, 1'b0);
        expect_pulse(k1 + 256, 0, 1'b0, "R8 B then A restarts");
        wait_drain();
        send(1, k);
        check_bit("R8 A alone keeps flag", expired, 1'b1);
        expect_pulse(k1 + 512, 0, 1'b0, "R8 A alone does not restart");
        wait_drain();
        send(2, k);
        expect_pulse(k + 256, 0, 1'b0, "R8 held A completed by B");
        wait_drain();

        // R9: sleep command clears flag and drops a half sequence
        send(1, k);
        send(3, k1);
        check_bit("R9 sleep clears flag", expired, 1'b0);
        send(2, k2);
        expect_pulse(k1 + 256, 0, 1'b0, "R9 half sequence discarded");
        wait_drain();

        // R5: timeout while asleep
        dual_mode = 1'b0;
        sleeping = 1'b1;
        send(3, k);
        expect_pulse(k + 256, 0, 1'b1, "R5 warm reset when asleep");
        wait_drain();
        check_bit("R5 flag after warm reset", expired, 1'b1);
        sleeping = 1'b0;

        // R10: kick on the terminal tick wins
        send(0, k);
        wait_to(k + 255);
        send(0, k1);
        check_bit("R10 flag low after coincident kick", expired, 1'b0);
        expect_pulse(k1 + 256, 0, 1'b0, "R10 full span after coincident kick");
        wait_drain();

        // R3: clock divided by four, oscillator ignored
        use_osc = 1'b0;
        send(0, k);
        expect_pulse(k + 1024, 3, 1'b0, "R3 divided clock source");
        wait_drain();
        use_osc = 1'b1;

        // R2 longest span
        span_sel = 3'd7;
        send(0, k);
        expect_pulse(k + 32768, 0, 1'b0, "R2 span code 7");
        wait_drain();

        // R1: reset clears flag mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_bit("R1 flag cleared by reset", expired, 1'b0);
        check_bit("R1 chip low in reset", chip_rst, 1'b0);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R11: %0d pulses left, expected 0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule